// File: doc/BRIEF.md
# Low-Power Hold Controller

This block decides when a small controller drops into its memory back-up state and when it comes back out. It watches an external hold pin, a software-set mode bit, and two single-cycle instruction pulses. One pulse asks for a full clock stop, which halts the oscillator and the CPU. The other asks for a wait, which halts only the CPU. While the block is in back-up it drives a clock-stop request, a CPU-halt request and an enable that forces every general output pin low.

Entry and release depend on the mode bit and on which instruction caused the entry. With the mode bit clear, a clock-stop is only accepted while the hold pin is low, and a rising hold pin ends it. With the mode bit set, a clock-stop is always accepted, and any change of the hold pin ends it. A wait always ends on any change of the hold pin. A clock-stop that is refused sets a sticky status flag.

The controller runs from an always-on clock. The hold pin goes through a two-stage synchronizer. Edges are found by comparing the synchronized level with the level captured at entry. The mode bit is also captured at entry, so the release rule cannot change while the block is in back-up.

Top module: `hold_ctrl`

## Requirements
- R1: After reset, clk_stop_req, cpu_halt_req, out_force_low and stop_refused are all 0.
- R2: With mode_sel=0 and the synchronized hold pin low, a ckstp_pulse in the run state sets clk_stop_req and cpu_halt_req on the next clock edge.
- R3: With mode_sel=0 and the synchronized hold pin high, a ckstp_pulse is refused. The outputs stay in the run state and stop_refused becomes 1. stop_refused stays 1 until the next accepted entry of either kind, which clears it.
- R4: With mode_sel=1, a ckstp_pulse enters clock-stop whatever the hold pin level is.
- R5: A clock-stop entered with mode_sel=0 ends when the hold pin goes high. The outputs return to 0 on the third clock edge after the pin changes, and not earlier.
- R6: A clock-stop entered with mode_sel=1 ends on any change of the hold pin, rising or falling.
- R7: A wait_pulse in the run state sets cpu_halt_req with clk_stop_req held at 0. The wait ends on any change of the hold pin.
- R8: out_force_low is 1 exactly while the block is in back-up, that is, while cpu_halt_req is 1.
- R9: The mode bit is captured at entry. Changing mode_sel during back-up does not change which hold pin event releases it.
- R10: In back-up, ckstp_pulse and wait_pulse are ignored. In the run state, ckstp_pulse takes priority over a wait_pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_pin | input | 1 | External hold request pin, asynchronous |
| mode_sel | input | 1 | Mode bit: 0 = clock-stop gated by the pin level, 1 = clock-stop always accepted |
| ckstp_pulse | input | 1 | One-cycle pulse from a clock-stop instruction |
| wait_pulse | input | 1 | One-cycle pulse from a wait instruction |
| clk_stop_req | output | 1 | Request to stop the oscillator |
| cpu_halt_req | output | 1 | Request to halt the CPU |
| out_force_low | output | 1 | Forces all general outputs low |
| stop_refused | output | 1 | Sticky flag: a clock-stop was refused |

## Verification
A wrong internal state shows up at the ports quickly. A bad captured level or captured mode makes a release come early, come late, or never come, and the bench sees this three edges after a pin change. A bad entry decision changes clk_stop_req, cpu_halt_req or stop_refused on the very next edge after the instruction pulse. Any mismatch between the halt request and the output-force enable is visible in every cycle.

// File: rtl/hold_pkg.sv
package hold_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_CKSTOP = 2'd1,
        PM_WAIT   = 2'd2
    } pm_state_e;

    typedef struct packed {
        pm_state_e state;
        logic      lvl;      // hold level captured at entry
        logic      mode;     // mode bit captured at entry
        logic      refused;  // sticky refused-entry flag
        logic      force_lo; // output force enable
    } pm_ctl_t;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sr_q[0] <= 1'b0;
                    else        sr_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sr_q[i] <= 1'b0;
                    else        sr_q[i] <= sr_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/hold_entry.sv
module hold_entry (
    input  logic running,
    input  logic ckstp,
    input  logic wait_req,
    input  logic mode,
    input  logic hold_s,
    output logic accept_stop,
    output logic refuse_stop,
    output logic accept_wait
);
    always_comb begin
        accept_stop = running && ckstp && (mode || !hold_s);
        refuse_stop = running && ckstp && !mode && hold_s;
        accept_wait = running && wait_req && !ckstp;
    end
endmodule

// File: rtl/hold_release.sv
module hold_release
    import hold_pkg::*;
(
    input  pm_state_e state,
    input  logic      lvl,
    input  logic      mode,
    input  logic      hold_s,
    output logic      release_now
);
    always_comb begin
        unique case (state)
            PM_CKSTOP: release_now = mode ? (hold_s != lvl) : hold_s;
            PM_WAIT:   release_now = (hold_s != lvl);
            default:   release_now = 1'b0;
        endcase
    end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
    import hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_pin,
    input  logic mode_sel,
    input  logic ckstp_pulse,
    input  logic wait_pulse,
    output logic clk_stop_req,
    output logic cpu_halt_req,
    output logic out_force_low,
    output logic stop_refused
);
    localparam pm_ctl_t CTL_RST = '{state: PM_RUN, lvl: 1'b0, mode: 1'b0,
                                    refused: 1'b0, force_lo: 1'b0};

    pm_ctl_t ctl_d, ctl_q;
    logic    hold_s;
    logic    accept_stop, refuse_stop, accept_wait, release_now;

    hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hold_pin),
        .dout (hold_s)
    );

    hold_entry u_entry (
        .running    (ctl_q.state == PM_RUN),
        .ckstp      (ckstp_pulse),
        .wait_req   (wait_pulse),
        .mode       (mode_sel),
        .hold_s     (hold_s),
        .accept_stop(accept_stop),
        .refuse_stop(refuse_stop),
        .accept_wait(accept_wait)
    );

    hold_release u_rel (
        .state      (ctl_q.state),
        .lvl        (ctl_q.lvl),
        .mode       (ctl_q.mode),
        .hold_s     (hold_s),
        .release_now(release_now)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.state == PM_RUN) begin
            if (accept_stop) begin
                ctl_d.state   = PM_CKSTOP;
                ctl_d.lvl     = hold_s;
                ctl_d.mode    = mode_sel;
                ctl_d.refused = 1'b0;
            end else if (refuse_stop) begin
                ctl_d.refused = 1'b1;
            end else if (accept_wait) begin
                ctl_d.state   = PM_WAIT;
                ctl_d.lvl     = hold_s;
                ctl_d.refused = 1'b0;
            end
        end else if (release_now) begin
            ctl_d.state = PM_RUN;
        end
        ctl_d.force_lo = (ctl_d.state != PM_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign clk_stop_req  = (ctl_q.state == PM_CKSTOP);
    assign cpu_halt_req  = (ctl_q.state != PM_RUN);
    assign out_force_low = ctl_q.force_lo;
    assign stop_refused  = ctl_q.refused;
endmodule

// File: rtl/hold_ctrl_chk.sv
module hold_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_s,
    input logic mode_sel,
    input logic ckstp_pulse,
    input logic wait_pulse,
    input logic clk_stop_req,
    input logic cpu_halt_req,
    input logic out_force_low,
    input logic stop_refused
);
    p_enter_m0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt_req && ckstp_pulse && !mode_sel && !hold_s) |=> clk_stop_req);

    p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt_req && ckstp_pulse && !mode_sel && hold_s) |=> (!cpu_halt_req && stop_refused));

    p_enter_m1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt_req && ckstp_pulse && mode_sel) |=> clk_stop_req);

    p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt_req && wait_pulse && !ckstp_pulse) |=> (cpu_halt_req && !clk_stop_req));

    p_force_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_force_low == cpu_halt_req);

    p_no_spurious_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt_req && $stable(hold_s)) |=> (cpu_halt_req && $stable(clk_stop_req)));
endmodule

bind hold_ctrl hold_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_s       (hold_s),
    .mode_sel     (mode_sel),
    .ckstp_pulse  (ckstp_pulse),
    .wait_pulse   (wait_pulse),
    .clk_stop_req (clk_stop_req),
    .cpu_halt_req (cpu_halt_req),
    .out_force_low(out_force_low),
    .stop_refused (stop_refused)
);

// File: tb/tb_hold_ctrl.sv
module tb_hold_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_pin = 1'b0;
    logic mode_sel = 1'b0;
    logic ckstp_pulse = 1'b0;
    logic wait_pulse = 1'b0;
    logic clk_stop_req, cpu_halt_req, out_force_low, stop_refused;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hold_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_pin     (hold_pin),
        .mode_sel     (mode_sel),
        .ckstp_pulse  (ckstp_pulse),
        .wait_pulse   (wait_pulse),
        .clk_stop_req (clk_stop_req),
        .cpu_halt_req (cpu_halt_req),
        .out_force_low(out_force_low),
        .stop_refused (stop_refused)
    );

    // packed view: {clk_stop, halt, force_low, refused}
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {clk_stop_req, cpu_halt_req, out_force_low, stop_refused};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic ncyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // change pin and let the synchronizer settle
    task automatic set_hold(input logic v);
        hold_pin = v;
        ncyc(3);
    endtask

    task automatic pulse(input logic ck, input logic wt);
        ckstp_pulse = ck;
        wait_pulse  = wt;
        @(negedge clk);
        ckstp_pulse = 1'b0;
        wait_pulse  = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", 4'b0000);
    endtask

    task automatic t_m0_stop;
        mode_sel = 1'b0;
        set_hold(1'b0);
        pulse(1'b1, 1'b0);
        check("R2 mode0 entry", 4'b1110);
        check("R8 force during backup", 4'b1110);
        hold_pin = 1'b1;
        ncyc(2);
        check("R5 not released before third edge", 4'b1110);
        ncyc(1);
        check("R5 released on rising hold", 4'b0000);
    endtask

    task automatic t_m0_refuse;
        mode_sel = 1'b0;
        set_hold(1'b1);
        pulse(1'b1, 1'b0);
        check("R3 refused entry", 4'b0001);
        ncyc(2);
        check("R3 flag sticky", 4'b0001);
        set_hold(1'b0);
        pulse(1'b1, 1'b0);
        check("R3 flag cleared on accepted entry", 4'b1110);
        set_hold(1'b1);
        check("R5 release after refuse test", 4'b0000);
    endtask

    task automatic t_m1_stop;
        mode_sel = 1'b1;
        set_hold(1'b1);
        pulse(1'b1, 1'b0);
        check("R4 mode1 entry with hold high", 4'b1110);
        set_hold(1'b0);
        check("R6 release on falling hold", 4'b0000);
        pulse(1'b1, 1'b0);
        check("R4 mode1 entry with hold low", 4'b1110);
        hold_pin = 1'b1;
        ncyc(2);
        check("R6 still held before third edge", 4'b1110);
        ncyc(1);
        check("R6 release on rising hold", 4'b0000);
    endtask

    task automatic t_wait;
        mode_sel = 1'b0;
        set_hold(1'b1);
        pulse(1'b0, 1'b1);
        check("R7 wait halts cpu only", 4'b0110);
        set_hold(1'b0);
        check("R7 wait release on falling", 4'b0000);
        pulse(1'b0, 1'b1);
        check("R7 wait entry hold low", 4'b0110);
        set_hold(1'b1);
        check("R7 wait release on rising", 4'b0000);
    endtask

    task automatic t_mode_capture;
        mode_sel = 1'b1;
        set_hold(1'b1);
        pulse(1'b1, 1'b0);
        check("R9 entry mode1", 4'b1110);
        mode_sel = 1'b0;
        set_hold(1'b0);
        check("R9 mode1 rule kept after mode change", 4'b0000);
        mode_sel = 1'b0;
        pulse(1'b1, 1'b0);
        check("R9 entry mode0", 4'b1110);
        mode_sel = 1'b1;
        ncyc(4);
        check("R9 mode0 rule kept, no release", 4'b1110);
        set_hold(1'b1);
        check("R9 mode0 release on rise", 4'b0000);
    endtask

    task automatic t_ignore;
        mode_sel = 1'b0;
        set_hold(1'b1);
        pulse(1'b0, 1'b1);
        check("R10 wait entered", 4'b0110);
        mode_sel = 1'b1;
        pulse(1'b1, 1'b0);
        check("R10 ckstp ignored in backup", 4'b0110);
        set_hold(1'b0);
        check("R10 release after ignored pulse", 4'b0000);
        pulse(1'b1, 1'b1);
        check("R10 ckstp wins over wait", 4'b1110);
        pulse(1'b0, 1'b1);
        check("R10 wait ignored in clock-stop", 4'b1110);
        set_hold(1'b1);
        check("R10 final release", 4'b0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        ncyc(3);
        rst_n = 1'b1;
        ncyc(1);
        t_reset();
        t_m0_stop();
        t_m0_refuse();
        t_m1_stop();
        t_wait();
        t_mode_capture();
        t_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule